// File: doc/BRIEF.md
# Triple-Redundant Voter with Standby Tile Exchange

This block sits behind three active 64-bit processing tiles and one standby tile. It combines the three active outputs into one word by bitwise two-of-three majority, so a single tile that goes wrong cannot reach the consumer. On every cycle with the valid strobe set, it compares each active tile with the voted word. A five-state health tracker then decides how to recover. The recovery can be to bring the standby tile out of reset, ask for its context to be copied, and put it in place of the faulted tile. It can also be to ask for an in-place repair.

The four physical tiles are numbered 0 to 3. A slot map records which physical tile feeds each of the three voting slots, and which tile is the standby. The standby is held in reset and disabled until it is needed. A tile that has been swapped out takes over the standby role. It stays in reset while a repair request for it is outstanding. The tiles, the context copy and the repair engine are outside the block. They appear only as request/done handshakes: a level request and a one-cycle done pulse.

Top module: `tmr_spare_mgr`

## Requirements
- R1: `vote_o` is, in the same cycle and without a register, the bitwise majority of the three tiles that the slot map currently marks active. After reset these are tiles 0, 1 and 2.
- R2: After reset, `health_o` is 0 (all healthy, standby available), and tile 3 is the standby. `tile_rst_n_o` is 4'b0111 and `tile_en_o` is 4'b0111. No request, no degraded flag and no fail flag is raised.
- R3: Tile outputs are judged only on cycles where `valid_i` is 1. With `valid_i`, `sync_done_i` and `rep_done_i` all low, the health state and the slot map do not change, whatever the tiles output.
- R4: In state 0, a single active tile that differs from `vote_o` moves the block to state 1 (awaiting swap). In state 1, `degraded_o` is 1 and `sync_req_o` is 1, with `sync_tile_o` naming the standby tile. That tile is then out of reset and enabled.
- R5: In state 1, a `sync_done_i` pulse gives the faulted slot to the standby tile. The faulted tile becomes the new standby and is held in reset. The block moves to state 2 (standby faulty), with `rep_req_o` set and `rep_tile_o` naming the new standby.
- R6: In state 0, a standby tile whose output is not all zeros while `valid_i` is 1 moves the block to state 2, with a repair request for that standby tile.
- R7: In state 2, a `rep_done_i` pulse with no active fault returns the block to state 0 and drops `rep_req_o`.
- R8: In state 2, a single active fault moves the block to state 3 (standby faulty and one active faulty). In state 3, `degraded_o` is 1 and `rep_tile_o` names the faulted active tile. If `rep_done_i` arrives in the same cycle as that fault, the block goes to state 1 instead.
- R9: In state 3, a `rep_done_i` pulse with no new fault returns the block to state 2, and `rep_tile_o` names the standby again.
- R10: The block moves to state 4 (failed) in three cases: two or more active tiles disagree in the same cycle in state 0 or 2; any active tile other than the known-faulty one disagrees in state 1; or any such tile disagrees in state 3.
- R11: State 4 drives `fail_o` to 1. The block stays in state 4 through any handshake or tile activity, until `rst_n` is low.
- R12: In state 0, a standby fault and a single active fault in the same cycle move the block directly to state 3, with the repair request naming the faulted active tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_dout_i | input | 4x64 | Output word of each physical tile, index = tile number |
| valid_i | input | 1 | Tile outputs are meaningful this cycle |
| vote_o | output | 64 | Bitwise majority of the three active tiles |
| tile_rst_n_o | output | 4 | Active-low reset per physical tile |
| tile_en_o | output | 4 | Enable per physical tile |
| sync_req_o | output | 1 | Context copy into the standby requested |
| sync_tile_o | output | 2 | Tile receiving the context copy |
| sync_done_i | input | 1 | Context copy finished (one-cycle pulse) |
| rep_req_o | output | 1 | Repair requested |
| rep_tile_o | output | 2 | Tile to be repaired |
| rep_done_i | input | 1 | Repair finished (one-cycle pulse) |
| health_o | output | 3 | Health state 0..4 |
| degraded_o | output | 1 | Output masked but redundancy reduced (states 1 and 3) |
| fail_o | output | 1 | Triad no longer trustworthy (state 4) |

## Verification
The bound checker watches several properties on every cycle. Agreement between two active tiles must set the vote. At most one tile may be in reset, and a tile receiving a context copy must be running. The failed state must be sticky. Idle cycles must leave the health state alone, and a finished copy must lead to the standby-faulty state. Only the bench's scenarios show that the slot map is rewritten correctly across repeated swaps from every slot. The same holds for the simultaneous-event priorities (standby and active fault together, repair completing as a new fault arrives) and for the choice of tile named in each request.

// File: rtl/tmr_pkg.sv
// Shared definitions for the redundant voter and standby exchange logic.
// Assumes exactly three voting slots and one standby, i.e. four tiles.
package tmr_pkg;
    localparam int NACT  = 3;
    localparam int NTILE = NACT + 1;
    localparam int IW    = $clog2(NTILE);
    localparam int SW    = $clog2(NACT);

    // Health tracker states; the numeric values are visible on health_o.
    typedef enum logic [2:0] {
        HL_OK    = 3'd0,   // all healthy, standby ready
        HL_SWAP  = 3'd1,   // active fault, standby being synchronized
        HL_SPBAD = 3'd2,   // standby under repair, actives healthy
        HL_DEGR  = 3'd3,   // standby under repair and one active faulty
        HL_FAIL  = 3'd4    // two faults in the triad: absorbing
    } health_e;
endpackage

// File: rtl/tmr_vote_unit.sv
// Bitwise two-of-three majority over the active slots plus per-slot
// disagreement flags. Assumes the standby, being held in reset while
// idle, must output all zeros; anything else counts as a standby fault.
// Purely combinational.
module tmr_vote_unit
    import tmr_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [NACT-1:0][W-1:0] act_data,
    input  logic [W-1:0]           spare_data,
    input  logic                   valid,
    output logic [W-1:0]           vote,
    output logic [NACT-1:0]        slot_miss,
    output logic                   spare_miss
);
    // Majority of the three slot words, bit by bit.
    always_comb begin
        vote = (act_data[0] & act_data[1]) |
               (act_data[0] & act_data[2]) |
               (act_data[1] & act_data[2]);
    end

    // One comparator per slot against the voted word.
    for (genvar s = 0; s < NACT; s++) begin : g_cmp
        assign slot_miss[s] = valid && (act_data[s] != vote);
    end

    // An idle standby must read back zero.
    assign spare_miss = valid && (spare_data != '0);
endmodule

// File: rtl/tmr_health_fsm.sv
// Five-state health tracker and slot map. Holds which physical tile feeds
// each voting slot, which tile is the standby and which slot is known bad.
// Assumes handshake done inputs are single-cycle pulses.
module tmr_health_fsm
    import tmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NACT-1:0]        slot_miss,
    input  logic                   spare_miss,
    input  logic                   sync_done,
    input  logic                   rep_done,
    output health_e                state,
    output logic [NACT-1:0][IW-1:0] slot_tile,
    output logic [IW-1:0]          spare_tile,
    output logic [SW-1:0]          flt_slot
);
    health_e               state_q, state_d;
    logic [NACT-1:0][IW-1:0] slot_q;
    logic [IW-1:0]         spare_q;
    logic [SW-1:0]         flt_q, flt_d;
    logic [NACT-1:0]       known, new_miss;
    logic [SW-1:0]         first;
    logic                  one_new, many_new, any_new, do_swap;

    // Separate fresh faults from the slot already known to be bad.
    always_comb begin
        known = '0;
        if (state_q == HL_SWAP || state_q == HL_DEGR) known[flt_q] = 1'b1;
        new_miss = slot_miss & ~known;
        any_new  = |new_miss;
        many_new = $countones(new_miss) > 1;
        one_new  = any_new && !many_new;
        first    = new_miss[0] ? SW'(0) : (new_miss[1] ? SW'(1) : SW'(2));
    end

    // Next-state and swap decision.
    always_comb begin
        state_d = state_q;
        flt_d   = flt_q;
        do_swap = 1'b0;
        unique case (state_q)
            HL_OK: begin
                if (many_new)                     state_d = HL_FAIL;
                else if (one_new && spare_miss) begin state_d = HL_DEGR; flt_d = first; end
                else if (one_new) begin           state_d = HL_SWAP; flt_d = first; end
                else if (spare_miss)              state_d = HL_SPBAD;
            end
            HL_SWAP: begin
                if (any_new)                      state_d = HL_FAIL;
                else if (sync_done) begin         state_d = HL_SPBAD; do_swap = 1'b1; end
            end
            HL_SPBAD: begin
                if (many_new)                     state_d = HL_FAIL;
                else if (one_new && rep_done) begin state_d = HL_SWAP; flt_d = first; end
                else if (one_new) begin           state_d = HL_DEGR; flt_d = first; end
                else if (rep_done)                state_d = HL_OK;
            end
            HL_DEGR: begin
                if (any_new)                      state_d = HL_FAIL;
                else if (rep_done)                state_d = HL_SPBAD;
            end
            default:                              state_d = HL_FAIL;
        endcase
    end

    // State, faulted-slot and slot-map registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HL_OK;
            flt_q   <= '0;
            slot_q  <= {IW'(2), IW'(1), IW'(0)};
            spare_q <= IW'(NTILE - 1);
        end else begin
            state_q <= state_d;
            flt_q   <= flt_d;
            if (do_swap) begin
                slot_q[flt_q] <= spare_q;
                spare_q       <= slot_q[flt_q];
            end
        end
    end

    assign state      = state_q;
    assign slot_tile  = slot_q;
    assign spare_tile = spare_q;
    assign flt_slot   = flt_q;
endmodule

// File: rtl/tmr_tile_ctrl.sv
// Per-tile reset and enable generation. The standby tile is held in reset
// and disabled except while it is being synchronized.
module tmr_tile_ctrl
    import tmr_pkg::*;
(
    input  health_e          state,
    input  logic [IW-1:0]    spare_tile,
    output logic [NTILE-1:0] tile_rst_n,
    output logic [NTILE-1:0] tile_en
);
    logic release_spare;

    // The standby only runs during the swap state.
    assign release_spare = (state == HL_SWAP);

    for (genvar t = 0; t < NTILE; t++) begin : g_tile
        logic is_spare;
        assign is_spare      = (spare_tile == IW'(t));
        assign tile_rst_n[t] = !is_spare || release_spare;
        assign tile_en[t]    = !is_spare || release_spare;
    end
endmodule

// File: rtl/tmr_spare_mgr.sv
// Top: routes physical tiles into voting slots through the slot map, votes,
// tracks health and drives the copy and repair handshakes.
// Assumes tile outputs are stable for the whole cycle in which they are valid.
module tmr_spare_mgr
    import tmr_pkg::*;
#(
    parameter int W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0][W-1:0]       tile_dout_i,
    input  logic                    valid_i,
    output logic [W-1:0]            vote_o,
    output logic [3:0]              tile_rst_n_o,
    output logic [3:0]              tile_en_o,
    output logic                    sync_req_o,
    output logic [1:0]              sync_tile_o,
    input  logic                    sync_done_i,
    output logic                    rep_req_o,
    output logic [1:0]              rep_tile_o,
    input  logic                    rep_done_i,
    output logic [2:0]              health_o,
    output logic                    degraded_o,
    output logic                    fail_o
);
    logic [NACT-1:0][W-1:0]  act_data;
    logic [W-1:0]            spare_data;
    logic [NACT-1:0]         slot_miss;
    logic                    spare_miss;
    health_e                 state;
    logic [NACT-1:0][IW-1:0] slot_tile;
    logic [IW-1:0]           spare_tile;
    logic [SW-1:0]           flt_slot;

    // Slot routing through the slot map.
    for (genvar s = 0; s < NACT; s++) begin : g_route
        assign act_data[s] = tile_dout_i[slot_tile[s]];
    end
    assign spare_data = tile_dout_i[spare_tile];

    tmr_vote_unit #(.W(W)) u_vote (
        .act_data   (act_data),
        .spare_data (spare_data),
        .valid      (valid_i),
        .vote       (vote_o),
        .slot_miss  (slot_miss),
        .spare_miss (spare_miss)
    );

    tmr_health_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_miss  (slot_miss),
        .spare_miss (spare_miss),
        .sync_done  (sync_done_i),
        .rep_done   (rep_done_i),
        .state      (state),
        .slot_tile  (slot_tile),
        .spare_tile (spare_tile),
        .flt_slot   (flt_slot)
    );

    tmr_tile_ctrl u_tiles (
        .state      (state),
        .spare_tile (spare_tile),
        .tile_rst_n (tile_rst_n_o),
        .tile_en    (tile_en_o)
    );

    // Handshake and status outputs decoded from the health state.
    always_comb begin
        sync_req_o  = (state == HL_SWAP);
        sync_tile_o = spare_tile;
        rep_req_o   = (state == HL_SPBAD) || (state == HL_DEGR);
        rep_tile_o  = (state == HL_DEGR) ? slot_tile[flt_slot] : spare_tile;
        health_o    = state;
        degraded_o  = (state == HL_SWAP) || (state == HL_DEGR);
        fail_o      = (state == HL_FAIL);
    end
endmodule

// File: rtl/tmr_spare_mgr_chk.sv
// Cycle-by-cycle property checker, bound to every tmr_spare_mgr instance.
module tmr_spare_mgr_chk #(
    parameter int W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0][W-1:0]  act_data,
    input logic [W-1:0]       vote_o,
    input logic               valid_i,
    input logic [3:0]         tile_rst_n_o,
    input logic [3:0]         tile_en_o,
    input logic               sync_req_o,
    input logic [1:0]         sync_tile_o,
    input logic               sync_done_i,
    input logic               rep_done_i,
    input logic [2:0]         health_o,
    input logic               fail_o
);
    // R1
    pair_sets_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_data[0] == act_data[1]) |-> (vote_o == act_data[0]));

    // R2
    single_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~tile_rst_n_o) <= 1);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !sync_done_i && !rep_done_i) |=> $stable(health_o));

    // R4
    sync_target_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req_o |-> (tile_rst_n_o[sync_tile_o] && tile_en_o[sync_tile_o]));

    // R5
    copy_done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (health_o == 3'd1 && sync_done_i && valid_i == 1'b0) |=> (health_o == 3'd2));

    // R9
    degr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (health_o == 3'd3 && rep_done_i) |=> (health_o == 3'd2 || health_o == 3'd4));

    // R11
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> fail_o);
endmodule

bind tmr_spare_mgr tmr_spare_mgr_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_data     (act_data),
    .vote_o       (vote_o),
    .valid_i      (valid_i),
    .tile_rst_n_o (tile_rst_n_o),
    .tile_en_o    (tile_en_o),
    .sync_req_o   (sync_req_o),
    .sync_tile_o  (sync_tile_o),
    .sync_done_i  (sync_done_i),
    .rep_done_i   (rep_done_i),
    .health_o     (health_o),
    .fail_o       (fail_o)
);

// File: tb/tmr_spare_mgr_tb.sv
module tmr_spare_mgr_tb;
    localparam int W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0][W-1:0] tile_dout;
    logic             valid_i = 1'b0, sync_done_i = 1'b0, rep_done_i = 1'b0;
    logic [W-1:0]     vote_o;
    logic [3:0]       tile_rst_n_o, tile_en_o;
    logic             sync_req_o, rep_req_o, degraded_o, fail_o;
    logic [1:0]       sync_tile_o, rep_tile_o;
    logic [2:0]       health_o;

    // Bench-side tile models.
    logic [W-1:0] golden = '0;
    logic [3:0]   bad = '0;     // tile drives a corrupted word while running
    logic [3:0]   inj = '0;     // tile drives nonzero while held in reset
    logic [1:0]   exp_slot [3];
    logic [1:0]   exp_spare;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_spare_mgr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tile_dout_i(tile_dout), .valid_i(valid_i),
        .vote_o(vote_o), .tile_rst_n_o(tile_rst_n_o), .tile_en_o(tile_en_o),
        .sync_req_o(sync_req_o), .sync_tile_o(sync_tile_o), .sync_done_i(sync_done_i),
        .rep_req_o(rep_req_o), .rep_tile_o(rep_tile_o), .rep_done_i(rep_done_i),
        .health_o(health_o), .degraded_o(degraded_o), .fail_o(fail_o)
    );

    // Each tile: golden word with a per-tile byte-sized flip, or zero in reset.
    always_comb begin
        for (int t = 0; t < 4; t++) begin
            if (tile_rst_n_o[t])
                tile_dout[t] = golden ^ (bad[t] ? (64'hFF << (t * 4)) : 64'h0);
            else
                tile_dout[t] = inj[t] ? (64'h1 << (t + 40)) : 64'h0;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected majority, counted bit by bit over the expected active tiles.
    task automatic vote_chk(input string tag);
        logic [W-1:0] e;
        for (int b = 0; b < W; b++) begin
            int c = 0;
            for (int k = 0; k < 3; k++) c += int'(tile_dout[exp_slot[k]][b]);
            e[b] = (c >= 2);
        end
        chk(tag, vote_o, e);
    endtask

    // Full status comparison for expected health h and repair target rt.
    task automatic status(input string tag, input int h, input logic [1:0] rt);
        logic [3:0] on;
        on = 4'hF;
        if (h != 1) on[exp_spare] = 1'b0;
        chk({tag, " health"}, W'(health_o), W'(h));
        chk({tag, " degraded"}, W'(degraded_o), W'(h == 1 || h == 3));
        chk({tag, " fail"}, W'(fail_o), W'(h == 4));
        chk({tag, " sync_req"}, W'(sync_req_o), W'(h == 1));
        if (h == 1) chk({tag, " sync_tile"}, W'(sync_tile_o), W'(exp_spare));
        chk({tag, " rep_req"}, W'(rep_req_o), W'(h == 2 || h == 3));
        if (h == 2 || h == 3) chk({tag, " rep_tile"}, W'(rep_tile_o), W'(rt));
        chk({tag, " tile_rst_n"}, W'(tile_rst_n_o), W'(on));
        chk({tag, " tile_en"}, W'(tile_en_o), W'(on));
    endtask

    // Drive one cycle (inputs set at a falling edge), check the vote, pass a rising edge.
    task automatic apply(input string tag, input logic v, input logic sd, input logic rd);
        valid_i = v; sync_done_i = sd; rep_done_i = rd;
        #1;
        vote_chk({tag, " vote R1"});
        @(negedge clk);
        valid_i = 1'b0; sync_done_i = 1'b0; rep_done_i = 1'b0; bad = '0; inj = '0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bad = '0; inj = '0;
        valid_i = 1'b0; sync_done_i = 1'b0; rep_done_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_slot[0] = 2'd0; exp_slot[1] = 2'd1; exp_slot[2] = 2'd2; exp_spare = 2'd3;
        #1;
    endtask

    task automatic swap_model(input int s);
        logic [1:0] tmp;
        tmp = exp_slot[s]; exp_slot[s] = exp_spare; exp_spare = tmp;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        golden = 64'h0123_4567_89AB_CDEF;
        status("R2 reset", 0, 2'd0);

        // R1/R3: every corruption subset, valid low so nothing is judged.
        for (int g = 0; g < 4; g++) begin
            golden = 64'h9E37_79B9_7F4A_7C15 * (g + 1);
            for (int m = 0; m < 8; m++) begin
                for (int k = 0; k < 3; k++) bad[exp_slot[k]] = m[k];
                inj[3] = m[0];
                apply("R1 sweep", 1'b0, 1'b0, 1'b0);
                status("R3 valid low ignored", 0, 2'd0);
            end
        end

        // R4/R5/R7: swap from each slot, twice, with the slot map rotating.
        for (int s = 0; s < 3; s++) begin
            do_reset();
            for (int rep = 0; rep < 2; rep++) begin
                golden = 64'hA5A5_0000_FFFF_1234 + 64'(s * 7 + rep);
                bad[exp_slot[s]] = 1'b1;
                apply("R4 fault", 1'b1, 1'b0, 1'b0);
                status("R4 awaiting swap", 1, 2'd0);
                apply("R5 idle in swap", 1'b1, 1'b0, 1'b0);
                status("R5 still swapping", 1, 2'd0);
                apply("R5 copy done", 1'b0, 1'b1, 1'b0);
                swap_model(s);
                status("R5 after swap", 2, exp_spare);
                apply("R7 repaired", 1'b1, 1'b0, 1'b1);
                status("R7 back to healthy", 0, 2'd0);
            end
        end

        // R6 then R7: standby reads nonzero.
        do_reset();
        inj[3] = 1'b1;
        apply("R6 spare fault", 1'b1, 1'b0, 1'b0);
        status("R6 spare under repair", 2, 2'd3);
        apply("R7 done", 1'b0, 1'b0, 1'b1);
        status("R7 healthy", 0, 2'd0);

        // R8, R9, R10, R11 chain.
        do_reset();
        inj[3] = 1'b1;
        apply("R8 prep", 1'b1, 1'b0, 1'b0);
        bad[0] = 1'b1;
        apply("R8 active fault", 1'b1, 1'b0, 1'b0);
        status("R8 degraded", 3, 2'd0);
        apply("R9 repair active", 1'b0, 1'b0, 1'b1);
        status("R9 back to spare repair", 2, 2'd3);
        bad[1] = 1'b1;
        apply("R8 second round", 1'b1, 1'b0, 1'b0);
        status("R8 degraded tile1", 3, 2'd1);
        bad[1] = 1'b1; bad[2] = 1'b1;
        apply("R10 fault in degraded", 1'b1, 1'b0, 1'b0);
        status("R10 failed", 4, 2'd0);
        for (int i = 0; i < 4; i++) begin
            bad = 4'(i * 5);
            apply("R11 activity", 1'b1, i[0], i[1]);
            status("R11 stays failed", 4, 2'd0);
        end
        do_reset();
        status("R11 reset leaves fail", 0, 2'd0);

        // R8: fault arriving with repair done goes straight to swap.
        inj[3] = 1'b1;
        apply("R8 prep2", 1'b1, 1'b0, 1'b0);
        bad[2] = 1'b1;
        apply("R8 fault+done", 1'b1, 1'b0, 1'b1);
        status("R8 to swap", 1, 2'd0);
        apply("R5 copy", 1'b0, 1'b1, 1'b0);
        swap_model(2);
        status("R5 swap slot2", 2, 2'd2);

        // R10: second active fault while swapping.
        do_reset();
        bad[0] = 1'b1;
        apply("R10 first", 1'b1, 1'b0, 1'b0);
        status("R10 swapping", 1, 2'd0);
        bad[1] = 1'b1;
        apply("R10 second", 1'b1, 1'b0, 1'b0);
        status("R10 fail in swap", 4, 2'd0);

        // R10: two simultaneous faults from healthy.
        do_reset();
        bad[0] = 1'b1; bad[2] = 1'b1;
        apply("R10 double", 1'b1, 1'b0, 1'b0);
        status("R10 double fail", 4, 2'd0);

        // R12: standby and active fault together.
        do_reset();
        inj[3] = 1'b1; bad[1] = 1'b1;
        apply("R12 both", 1'b1, 1'b0, 1'b0);
        status("R12 degraded", 3, 2'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule